// File: doc/BRIEF.md
# Banked Special Register File

This block holds the control and status registers of a small 8-bit microcontroller core. The core presents a 7-bit in-bank offset. The register file combines that offset with the bank bit stored in its own status register, giving an 8-bit effective address. It then decides whether the access lands on one of its registers, on a location that always reads zero, or on general-purpose data memory outside the block. In the last case it drives a memory address and a write strobe outward.

Offset zero is a virtual location. Any access there is carried out at the address held in the pointer register, so software can reach any data location, including the special registers themselves. A group of core registers appears at the same offsets in both banks. The other offsets hold bank-specific registers. Peripheral registers are plain storage in this block.

Two synchronous reset inputs give different reset values. The power-on reset has priority over the warm reset, which covers the external pin and the watchdog. The upper-program-counter latch is presented continuously to the program counter logic and has no path back into it.

Top module: `sfr_file`

## Requirements
- R1: Effective address is {STATUS bit 5, offset}. At offsets 01h/05h/06h/08h/09h, bank 0 holds timer, port A latch, port B latch, EE data and EE address, and bank 1 holds option (01h), port A direction (05h), port B direction (06h) and EE control (08h). Bank 1 offset 09h reads zero and ignores writes. Offsets 0Ch–7Fh assert mem_sel with mem_addr equal to the effective address, and mem_we equals acc_we there.
- R2: Offsets 02h (PC low), 03h (STATUS), 04h (pointer), 0Ah (PC-high latch) and 0Bh (interrupt control) reach the same register in either bank.
- R3: An access at offset 00h uses the pointer value as effective address, with pointer bit 7 as the bank bit. It reads or writes the target register, or drives mem_addr/mem_we for a memory target. ptr_out always shows the pointer.
- R4: An access at offset 00h whose pointer has low 7 bits zero (00h or 80h) reads zero, changes no register and keeps mem_we low.
- R5: Offset 07h in either bank reads zero and writes to it change nothing.
- R6: PC-high latch, port A latch, port A direction and EE control keep bits 4:0 only; bits 7:5 read zero. pc_hi always equals the PC-high latch bits 4:0.
- R7: Power-on reset sets STATUS=18h (TO bit 4 and PD bit 3 set), option=FFh, port A direction=1Fh, port B direction=FFh, and every other register to 00h.
- R8: Warm reset clears STATUS bits 7:5 and keeps bits 4:0. It sets option=FFh and both direction registers to all ones, clears interrupt-control bits 7:1 while keeping bit 0, and clears PC low and the PC-high latch. All other registers keep their values.
- R9: When both resets are high, the power-on values of R7 apply.
- R10: acc_rdata reflects the addressed location in the same cycle. A write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous power-on reset, active high |
| rst_warm | input | 1 | Synchronous pin/watchdog reset, active high |
| acc_off | input | 7 | In-bank offset of the core access |
| acc_we | input | 1 | Write strobe of the core access |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the addressed location |
| mem_sel | output | 1 | Effective address lies in data memory |
| mem_addr | output | 8 | Effective address |
| mem_we | output | 1 | Write strobe to data memory |
| mem_rdata | input | 8 | Read data from data memory |
| ptr_out | output | 8 | Current pointer register value |
| pc_hi | output | 5 | PC-high latch toward the program counter |

## Verification
A wrong bank bit or a wrong pointer value changes where the next access lands. The error shows at once on mem_addr, or as data read back from the wrong register. A register corrupted by an access that should be ignored becomes visible on the first read of that register, which the bench makes straight after the suspect write. Wrong reset values show on the first reads after a reset pulse. A warm reset that wrongly touches the status flags or the pointer shows on the read of that register.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int OFF_W    = 7;
    localparam int DW       = 8;
    localparam int EA_W     = OFF_W + 1;
    localparam int NARROW_W = 5;
    localparam int PAD_W    = DW - NARROW_W;

    localparam logic [OFF_W-1:0] OFF_INDIR  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_TMR    = 7'h01;
    localparam logic [OFF_W-1:0] OFF_PCL    = 7'h02;
    localparam logic [OFF_W-1:0] OFF_STAT   = 7'h03;
    localparam logic [OFF_W-1:0] OFF_PTR    = 7'h04;
    localparam logic [OFF_W-1:0] OFF_PA     = 7'h05;
    localparam logic [OFF_W-1:0] OFF_PB     = 7'h06;
    localparam logic [OFF_W-1:0] OFF_GAP    = 7'h07;
    localparam logic [OFF_W-1:0] OFF_EDAT   = 7'h08;
    localparam logic [OFF_W-1:0] OFF_EADR   = 7'h09;
    localparam logic [OFF_W-1:0] OFF_PCH    = 7'h0A;
    localparam logic [OFF_W-1:0] OFF_INTC   = 7'h0B;
    localparam logic [OFF_W-1:0] OFF_RAM_LO = 7'h0C;

    // status bit positions that other logic depends on
    localparam int ST_RP0 = 5;
    localparam int ST_TO  = 4;
    localparam int ST_PD  = 3;

    typedef enum logic [4:0] {
        SEL_ZERO, SEL_NULL, SEL_RAM,
        SEL_TMR, SEL_PCL, SEL_STAT, SEL_PTR, SEL_PA, SEL_PB,
        SEL_EDAT, SEL_EADR, SEL_PCH, SEL_INTC,
        SEL_OPT, SEL_TRA, SEL_TRB, SEL_ECON
    } sel_e;

    typedef struct packed {
        logic [DW-1:0]       pcl;
        logic [DW-1:0]       stat;
        logic [DW-1:0]       ptr;
        logic [NARROW_W-1:0] pch;
        logic [DW-1:0]       intc;
        logic [DW-1:0]       tmr;
        logic [NARROW_W-1:0] pa;
        logic [DW-1:0]       pb;
        logic [DW-1:0]       edat;
        logic [DW-1:0]       eadr;
        logic [DW-1:0]       opt;
        logic [NARROW_W-1:0] tra;
        logic [DW-1:0]       trb;
        logic [NARROW_W-1:0] econ;
    } regs_t;
endpackage

// File: rtl/sfr_decode.sv
module sfr_decode
    import sfr_pkg::*;
(
    input  logic [OFF_W-1:0] acc_off,
    input  logic             rp0,
    input  logic [EA_W-1:0]  ptr,
    output logic [EA_W-1:0]  ea,
    output sel_e             sel
);
    logic             indirect;
    logic             hi;
    logic [OFF_W-1:0] off;

    always_comb begin
        indirect = (acc_off == OFF_INDIR);
        ea       = indirect ? ptr : {rp0, acc_off};
        off      = ea[OFF_W-1:0];
        hi       = ea[EA_W-1];
        case (off)
            OFF_INDIR: sel = SEL_NULL;
            OFF_TMR:   sel = hi ? SEL_OPT : SEL_TMR;
            OFF_PCL:   sel = SEL_PCL;
            OFF_STAT:  sel = SEL_STAT;
            OFF_PTR:   sel = SEL_PTR;
            OFF_PA:    sel = hi ? SEL_TRA : SEL_PA;
            OFF_PB:    sel = hi ? SEL_TRB : SEL_PB;
            OFF_GAP:   sel = SEL_ZERO;
            OFF_EDAT:  sel = hi ? SEL_ECON : SEL_EDAT;
            OFF_EADR:  sel = hi ? SEL_ZERO : SEL_EADR;
            OFF_PCH:   sel = SEL_PCH;
            OFF_INTC:  sel = SEL_INTC;
            default:   sel = (off >= OFF_RAM_LO) ? SEL_RAM : SEL_ZERO;
        endcase
    end
endmodule

// File: rtl/sfr_regs.sv
module sfr_regs
    import sfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_por,
    input  logic                rst_warm,
    input  sel_e                sel,
    input  logic                we,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic                rp0,
    output logic [EA_W-1:0]     ptr,
    output logic [NARROW_W-1:0] pc_hi
);
    localparam logic [DW-1:0]       ONES_W  = '1;
    localparam logic [NARROW_W-1:0] ONES_N  = '1;
    localparam logic [DW-1:0]       STAT_POR = (DW'(1) << ST_TO) | (DW'(1) << ST_PD);

    regs_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (rst_por) begin
            q_d      = '0;
            q_d.stat = STAT_POR;
            q_d.opt  = ONES_W;
            q_d.tra  = ONES_N;
            q_d.trb  = ONES_W;
        end else if (rst_warm) begin
            q_d.stat[DW-1:ST_RP0] = '0;
            q_d.opt               = ONES_W;
            q_d.tra               = ONES_N;
            q_d.trb               = ONES_W;
            q_d.intc[DW-1:1]      = '0;
            q_d.pcl               = '0;
            q_d.pch               = '0;
        end else if (we) begin
            case (sel)
                SEL_TMR:  q_d.tmr  = wdata;
                SEL_PCL:  q_d.pcl  = wdata;
                SEL_STAT: q_d.stat = wdata;
                SEL_PTR:  q_d.ptr  = wdata;
                SEL_PA:   q_d.pa   = wdata[NARROW_W-1:0];
                SEL_PB:   q_d.pb   = wdata;
                SEL_EDAT: q_d.edat = wdata;
                SEL_EADR: q_d.eadr = wdata;
                SEL_PCH:  q_d.pch  = wdata[NARROW_W-1:0];
                SEL_INTC: q_d.intc = wdata;
                SEL_OPT:  q_d.opt  = wdata;
                SEL_TRA:  q_d.tra  = wdata[NARROW_W-1:0];
                SEL_TRB:  q_d.trb  = wdata;
                SEL_ECON: q_d.econ = wdata[NARROW_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    always_comb begin
        case (sel)
            SEL_TMR:  rdata = q_q.tmr;
            SEL_PCL:  rdata = q_q.pcl;
            SEL_STAT: rdata = q_q.stat;
            SEL_PTR:  rdata = q_q.ptr;
            SEL_PA:   rdata = {{PAD_W{1'b0}}, q_q.pa};
            SEL_PB:   rdata = q_q.pb;
            SEL_EDAT: rdata = q_q.edat;
            SEL_EADR: rdata = q_q.eadr;
            SEL_PCH:  rdata = {{PAD_W{1'b0}}, q_q.pch};
            SEL_INTC: rdata = q_q.intc;
            SEL_OPT:  rdata = q_q.opt;
            SEL_TRA:  rdata = {{PAD_W{1'b0}}, q_q.tra};
            SEL_TRB:  rdata = q_q.trb;
            SEL_ECON: rdata = {{PAD_W{1'b0}}, q_q.econ};
            default:  rdata = '0;
        endcase
    end

    assign rp0   = q_q.stat[ST_RP0];
    assign ptr   = q_q.ptr;
    assign pc_hi = q_q.pch;

    // R7 / R9: power-on reset wins and loads its values
    p_por_defaults_r7: assert property (@(posedge clk) disable iff (1'b0)
        rst_por |=> (q_q.stat == STAT_POR && q_q.opt == ONES_W &&
                     q_q.trb == ONES_W && q_q.ptr == '0));

    // R8: warm reset preserves the timeout and power-down flags
    p_warm_flags_r8: assert property (@(posedge clk) disable iff (rst_por)
        rst_warm |=> (q_q.stat[ST_TO:ST_PD] == $past(q_q.stat[ST_TO:ST_PD]) &&
                      q_q.ptr == $past(q_q.ptr)));

    // R8: warm reset turns all port pins into inputs
    p_warm_tris_r8: assert property (@(posedge clk) disable iff (rst_por)
        rst_warm |=> (q_q.tra == ONES_N && q_q.trb == ONES_W));

    // R4 / R5: writes to gap, null indirection or missing register leave state alone
    p_ignored_write_r5: assert property (@(posedge clk) disable iff (rst_por || rst_warm)
        (we && (sel == SEL_ZERO || sel == SEL_NULL || sel == SEL_RAM)) |=> $stable(q_q));
endmodule

// File: rtl/sfr_file.sv
module sfr_file
    import sfr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_por,
    input  logic                rst_warm,
    input  logic [OFF_W-1:0]    acc_off,
    input  logic                acc_we,
    input  logic [DW-1:0]       acc_wdata,
    output logic [DW-1:0]       acc_rdata,
    output logic                mem_sel,
    output logic [EA_W-1:0]     mem_addr,
    output logic                mem_we,
    input  logic [DW-1:0]       mem_rdata,
    output logic [EA_W-1:0]     ptr_out,
    output logic [NARROW_W-1:0] pc_hi
);
    sel_e            sel;
    logic            rp0;
    logic [EA_W-1:0] ptr;
    logic [EA_W-1:0] ea;
    logic [DW-1:0]   reg_rdata;
    logic            reg_we;

    sfr_decode i_decode (
        .acc_off (acc_off),
        .rp0     (rp0),
        .ptr     (ptr),
        .ea      (ea),
        .sel     (sel)
    );

    always_comb begin
        mem_sel   = (sel == SEL_RAM);
        mem_addr  = ea;
        mem_we    = acc_we && mem_sel;
        reg_we    = acc_we && !mem_sel;
        acc_rdata = mem_sel ? mem_rdata : reg_rdata;
        ptr_out   = ptr;
    end

    sfr_regs i_regs (
        .clk      (clk),
        .rst_por  (rst_por),
        .rst_warm (rst_warm),
        .sel      (sel),
        .we       (reg_we),
        .wdata    (acc_wdata),
        .rdata    (reg_rdata),
        .rp0      (rp0),
        .ptr      (ptr),
        .pc_hi    (pc_hi)
    );

    // R5: the gap offset always reads zero
    p_gap_zero_r5: assert property (@(posedge clk) disable iff (rst_por)
        (acc_off == OFF_GAP) |-> (acc_rdata == '0 && !mem_we));

    // R4: self-pointing indirection reads zero and never strobes memory
    p_null_zero_r4: assert property (@(posedge clk) disable iff (rst_por)
        (acc_off == OFF_INDIR && ptr_out[OFF_W-1:0] == '0) |-> (acc_rdata == '0 && !mem_we));
endmodule

// File: tb/test_sfr_file.sv
module test_sfr_file;
    logic       clk = 1'b0;
    logic       rst_por = 1'b0;
    logic       rst_warm = 1'b0;
    logic [6:0] acc_off = '0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       mem_sel;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_rdata = 8'h3C;
    logic [7:0] ptr_out;
    logic [4:0] pc_hi;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sfr_file i_sfr_file (
        .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm),
        .acc_off(acc_off), .acc_we(acc_we), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .ptr_out(ptr_out), .pc_hi(pc_hi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] off, input logic [7:0] d);
        @(negedge clk);
        acc_off = off; acc_we = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [6:0] off, input logic [7:0] exp);
        acc_off = off; acc_we = 1'b0;
        #1;
        chk(req, acc_rdata, exp);
    endtask

    task automatic do_reset(input bit por, input bit warm);
        @(negedge clk);
        rst_por = por; rst_warm = warm;
        @(negedge clk);
        rst_por = 1'b0; rst_warm = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(1, 0);
        rd("R7 status", 7'h03, 8'h18);
        rd("R7 tmr0", 7'h01, 8'h00);
        rd("R7 pointer", 7'h04, 8'h00);
        wr(7'h03, 8'h20);
        rd("R7 option", 7'h01, 8'hFF);
        rd("R7 dirA", 7'h05, 8'h1F);
        rd("R7 dirB", 7'h06, 8'hFF);
        rd("R7 intc", 7'h0B, 8'h00);
        wr(7'h03, 8'h18);
    endtask

    task automatic t_banks;
        wr(7'h06, 8'hA5);
        wr(7'h09, 8'h3E);
        rd("R10 port B latch", 7'h06, 8'hA5);
        wr(7'h03, 8'h38);
        rd("R1 bank1 dirB unaffected", 7'h06, 8'hFF);
        wr(7'h09, 8'h77);
        rd("R1 bank1 09h reads zero", 7'h09, 8'h00);
        wr(7'h01, 8'h12);
        rd("R1 option", 7'h01, 8'h12);
        wr(7'h04, 8'h5A);
        wr(7'h03, 8'h18);
        rd("R1 EE address kept", 7'h09, 8'h3E);
        rd("R2 pointer mirrored", 7'h04, 8'h5A);
        rd("R1 timer distinct from option", 7'h01, 8'h00);
    endtask

    task automatic t_mirror;
        wr(7'h0B, 8'hC3);
        wr(7'h03, 8'h38);
        rd("R2 intc from bank1", 7'h0B, 8'hC3);
        wr(7'h02, 8'h9D);
        wr(7'h03, 8'h18);
        rd("R2 PC low from bank0", 7'h02, 8'h9D);
    endtask

    task automatic t_indirect;
        wr(7'h04, 8'h86);
        wr(7'h00, 8'h0F);
        wr(7'h03, 8'h38);
        rd("R3 indirect wrote dirB", 7'h06, 8'h0F);
        wr(7'h03, 8'h18);
        rd("R3 indirect read", 7'h00, 8'h0F);
        wr(7'h04, 8'hB0);
        acc_off = 7'h00; acc_we = 1'b1; acc_wdata = 8'h44;
        #1;
        chk("R3 mem_sel", {7'b0, mem_sel}, 8'h01);
        chk("R3 mem_addr", mem_addr, 8'hB0);
        chk("R3 mem_we", {7'b0, mem_we}, 8'h01);
        chk("R3 mem read data", acc_rdata, 8'h3C);
        chk("R3 ptr_out", ptr_out, 8'hB0);
        @(negedge clk);
        acc_we = 1'b0;
        acc_off = 7'h20; acc_we = 1'b1;
        #1;
        chk("R1 direct mem_addr", mem_addr, 8'h20);
        chk("R1 direct mem_we", {7'b0, mem_we}, 8'h01);
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic t_null;
        wr(7'h04, 8'h80);
        acc_off = 7'h00; acc_we = 1'b1; acc_wdata = 8'hAA;
        #1;
        chk("R4 null read", acc_rdata, 8'h00);
        chk("R4 no mem write", {7'b0, mem_we}, 8'h00);
        @(negedge clk);
        acc_we = 1'b0;
        rd("R4 pointer unchanged", 7'h04, 8'h80);
        rd("R4 status unchanged", 7'h03, 8'h18);
    endtask

    task automatic t_gap;
        wr(7'h07, 8'hFF);
        rd("R5 gap bank0", 7'h07, 8'h00);
        rd("R5 no side write on status", 7'h03, 8'h18);
        wr(7'h03, 8'h38);
        rd("R5 gap bank1", 7'h07, 8'h00);
        wr(7'h03, 8'h18);
    endtask

    task automatic t_narrow;
        wr(7'h0A, 8'hFF);
        rd("R6 PC-high latch", 7'h0A, 8'h1F);
        #1 chk("R6 pc_hi", {3'b0, pc_hi}, 8'h1F);
        wr(7'h05, 8'hE6);
        rd("R6 port A latch", 7'h05, 8'h06);
        wr(7'h03, 8'h38);
        wr(7'h05, 8'hE0);
        rd("R6 dirA", 7'h05, 8'h00);
        wr(7'h08, 8'hFF);
        rd("R6 EE control", 7'h08, 8'h1F);
        wr(7'h03, 8'h18);
    endtask

    task automatic t_warm;
        wr(7'h0B, 8'hFF);
        wr(7'h04, 8'h55);
        wr(7'h06, 8'hA5);
        wr(7'h02, 8'h40);
        wr(7'h0A, 8'h13);
        wr(7'h03, 8'h27);
        wr(7'h06, 8'h00);
        do_reset(0, 1);
        rd("R8 status", 7'h03, 8'h07);
        rd("R8 intc", 7'h0B, 8'h01);
        rd("R8 pointer kept", 7'h04, 8'h55);
        rd("R8 port B kept", 7'h06, 8'hA5);
        rd("R8 PC low", 7'h02, 8'h00);
        rd("R8 PC-high latch", 7'h0A, 8'h00);
        wr(7'h03, 8'h27);
        rd("R8 dirB", 7'h06, 8'hFF);
        rd("R8 dirA", 7'h05, 8'h1F);
        rd("R8 option", 7'h01, 8'hFF);
    endtask

    task automatic t_both;
        do_reset(1, 1);
        rd("R9 status", 7'h03, 8'h18);
        rd("R9 pointer", 7'h04, 8'h00);
        rd("R9 port B", 7'h06, 8'h00);
    endtask

    initial begin
        t_reset_state();
        t_banks();
        t_mirror();
        t_indirect();
        t_null();
        t_gap();
        t_narrow();
        t_warm();
        t_both();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule